// File: doc/BRIEF.md
# Status-Reporting I2C Bus Master

This block drives an I2C bus as a master, one byte at a time, under software control. Software enables it, chooses a bit rate and requests a START. The controller then waits until the bus is idle and issues the START condition. After every bus event (START, repeated START, a byte with its acknowledge slot, or lost arbitration) it sets an interrupt flag and publishes an 8-bit status code. It then holds SCL low until software clears the flag.

Whatever sits in the data register when the flag is cleared is what goes out next. After a START this is the address byte, whose bit 0 selects reading (1) or writing (0). After that it is the data bytes. In the read direction, received bytes land in the data register, and an acknowledge-enable bit chooses whether the master answers ACK or NACK. Setting the stop request produces a STOP, and setting the start request while the bus is held produces a repeated START.

Top module: `i2c_event_master`

## Requirements
- R1: After reset the control readback is 00h, the status is F8h, the interrupt flag is 0, and neither bus line is driven.
- R2: With the enable bit (control bit 4) and the start request (control bit 3) set, START is issued only when no other master owns the bus, which means no START has been seen on the lines since the last STOP. Once START completes, the flag is set and the status is 08h.
- R3: While the flag (control bit 1, readable on `irq_o`) is set, SCL is held low and nothing changes on the bus. Software clears the flag by writing 0 to bit 1. Writing 1 to bit 1 never sets the flag.
- R4: On the first byte after 08h or 10h, the data register is sent MSB first. The status then becomes 18h for write and ACK, 20h for write and NACK, 40h for read and ACK, or 48h for read and NACK. Bit 0 of the address byte set to 1 selects receive mode for the bytes that follow.
- R5: A data byte sent in transmit mode ends with status 28h if the slave acknowledged it and 30h if it did not.
- R6: In receive mode the byte arrives in the data register MSB first. The master drives ACK when control bit 0 is 1 and leaves NACK otherwise, and the status becomes 50h or 58h to match.
- R7: Setting the start request while the bus is held, with the flag cleared in the same write, produces a repeated START and status 10h.
- R8: Setting the stop request (control bit 2) while the bus is held produces a STOP. The controller then releases both lines, returns to status F8h with the flag clear, and clears the stop request itself.
- R9: The SCL period in clock cycles equals the divider picked by the rate field (control bits 7:5). Codes 0 to 6 select 128, 112, 96, 80, 480, 60 and 30. Code 7 selects 96 × (256 − reload), where the reload byte is written at select 2.
- R10: Inside a byte transfer, SDA changes only while SCL is low.
- R11: If the master releases SDA to send a 1 and then samples it low, the status becomes 38h, the flag is set and both lines are released.
- R12: The enable bit and the rate field change only through software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 data, 2 timer reload |
| wr_data | input | 8 | Write value |
| ctrl_o | output | 8 | Control readback {rate[2:0], enable, start, stop, flag, ack_enable} |
| status_o | output | 8 | Status code of the last event |
| data_o | output | 8 | Data register (received byte after a read) |
| irq_o | output | 1 | Interrupt flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situations to reach from the ports are a bus already owned by another master and a lost arbitration. Both need a second driver on the wired-AND lines. The bench has an extra open-drain SDA driver that fakes a foreign START, with SCL high and no STOP following, while a start request waits. It releases the line later to form the STOP the controller is waiting for. The same driver holds SDA low while the controller is stalled ahead of an address byte whose first bit is 1, which forces the arbitration-loss path.

// File: rtl/i2c_event_master.sv
module i2c_event_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o,
  output logic [7:0] data_o,
  output logic       irq_o,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  localparam logic [7:0] S_START = 8'h08, S_RSTART = 8'h10, S_AW_ACK = 8'h18, S_AW_NAK = 8'h20;
  localparam logic [7:0] S_DW_ACK = 8'h28, S_DW_NAK = 8'h30, S_LOST = 8'h38, S_AR_ACK = 8'h40;
  localparam logic [7:0] S_AR_NAK = 8'h48, S_DR_ACK = 8'h50, S_DR_NAK = 8'h58, S_IDLE = 8'hF8;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_RSTART, ST_BIT, ST_STOP, ST_HOLD} st_t;
  st_t st;

  logic       en, start_req, stop_req, flag, ack_en;
  logic [2:0] rate;
  logic [7:0] dat, reload, status, shreg;
  logic [1:0] ph;
  logic [14:0] cnt;
  logic [3:0] bitn;
  logic       samp, rd_mode, is_addr, addr_next, busy;
  logic       scl_q, sda_q, sda_p, sda_last;
  logic       scl_drv, sda_drv;

  logic [8:0]  tspan;
  logic [14:0] div, cnt_load;
  logic [1:0]  ph_in;
  logic        rx_byte, bitlow;
  logic [7:0]  end_code;

  assign tspan = 9'd256 - {1'b0, reload};
  always_comb begin
    case (rate)
      3'd0: div = 15'd128;
      3'd1: div = 15'd112;
      3'd2: div = 15'd96;
      3'd3: div = 15'd80;
      3'd4: div = 15'd480;
      3'd5: div = 15'd60;
      3'd6: div = 15'd30;
      default: div = {tspan, 6'b0} + {1'b0, tspan, 5'b0};
    endcase
  end

  assign ph_in    = ph + 2'd1;
  assign cnt_load = {2'b0, div[14:2]} + {14'd0, (ph_in < div[1:0])} - 15'd1;
  assign rx_byte  = rd_mode & ~is_addr;
  assign bitlow   = bitn[3] ? (rx_byte & ack_en) : (~rx_byte & ~shreg[7]);
  assign end_code = is_addr ? (rd_mode ? (samp ? S_AR_NAK : S_AR_ACK) : (samp ? S_AW_NAK : S_AW_ACK))
                  : rx_byte ? (ack_en ? S_DR_ACK : S_DR_NAK)
                  : (samp ? S_DW_NAK : S_DW_ACK);

  always_comb begin
    case (st)
      ST_START:  begin scl_drv = 1'b0;      sda_drv = ph[1];       end
      ST_RSTART: begin scl_drv = (ph == 0); sda_drv = ph[1];       end
      ST_STOP:   begin scl_drv = (ph == 0); sda_drv = (ph != 2'd3); end
      ST_BIT:    begin scl_drv = ~ph[1];    sda_drv = bitlow;      end
      ST_HOLD:   begin scl_drv = 1'b1;      sda_drv = sda_last;    end
      default:   begin scl_drv = 1'b0;      sda_drv = 1'b0;        end
    endcase
  end

  assign scl_drive_low = scl_drv;
  assign sda_drive_low = sda_drv;
  assign ctrl_o   = {rate, en, start_req, stop_req, flag, ack_en};
  assign status_o = status;
  assign data_o   = dat;
  assign irq_o    = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; en <= 1'b0; start_req <= 1'b0; stop_req <= 1'b0; flag <= 1'b0;
      ack_en <= 1'b0; rate <= 3'd0; dat <= 8'h00; reload <= 8'h00; status <= S_IDLE;
      shreg <= 8'h00; ph <= 2'd3; cnt <= '0; bitn <= 4'd0; samp <= 1'b1;
      rd_mode <= 1'b0; is_addr <= 1'b0; addr_next <= 1'b0; busy <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1; sda_last <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      sda_p <= sda_q;
      if (scl_q && sda_p && !sda_q) busy <= 1'b1;
      else if (scl_q && !sda_p && sda_q) busy <= 1'b0;
      if (st != ST_HOLD) sda_last <= sda_drv;

      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            ack_en <= wr_data[0]; flag <= flag & wr_data[1]; stop_req <= wr_data[2];
            start_req <= wr_data[3]; en <= wr_data[4]; rate <= wr_data[7:5];
          end
          2'd1: dat <= wr_data;
          2'd2: reload <= wr_data;
          default: ;
        endcase
      end

      if (!en) begin
        st <= ST_IDLE;
        ph <= 2'd3;
      end else begin
        case (st)
          ST_IDLE:
            if (start_req && !flag && !busy && scl_q && sda_q) begin
              st <= ST_START; ph <= 2'd0; cnt <= cnt_load;
            end
          ST_HOLD:
            if (!flag) begin
              ph <= 2'd0; cnt <= cnt_load;
              if (stop_req) st <= ST_STOP;
              else if (start_req) st <= ST_RSTART;
              else begin
                st <= ST_BIT; bitn <= 4'd0; shreg <= dat;
                is_addr <= addr_next; addr_next <= 1'b0;
                if (addr_next) rd_mode <= dat[0];
              end
            end
          default:
            if (cnt != 0) cnt <= cnt - 15'd1;
            else if (st == ST_BIT && ph == 2'd2 && !bitn[3] && !rx_byte && shreg[7] && !sda_q) begin
              st <= ST_IDLE; ph <= 2'd3; flag <= 1'b1; status <= S_LOST;
            end else begin
              if (st == ST_BIT && ph == 2'd2) samp <= sda_q;
              ph <= ph_in; cnt <= cnt_load;
              if (ph == 2'd3) begin
                case (st)
                  ST_START:  begin st <= ST_HOLD; flag <= 1'b1; status <= S_START;  addr_next <= 1'b1; end
                  ST_RSTART: begin st <= ST_HOLD; flag <= 1'b1; status <= S_RSTART; addr_next <= 1'b1; end
                  ST_STOP:   begin st <= ST_IDLE; status <= S_IDLE; stop_req <= 1'b0; end
                  default:
                    if (!bitn[3]) begin
                      bitn <= bitn + 4'd1; shreg <= {shreg[6:0], samp};
                    end else begin
                      st <= ST_HOLD; flag <= 1'b1; status <= end_code;
                      if (rx_byte) dat <= shreg;
                    end
                endcase
              end
            end
        endcase
      end
    end
  end

  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (scl_drv || st == ST_IDLE));

  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && !scl_drv && $past(st == ST_BIT && !scl_drv)) |-> $stable(sda_drv));

  p_start_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $past(st == ST_IDLE)) |-> !$past(busy));

  p_stop_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && st == ST_STOP && ph == 2'd3 && cnt == 0) |-> (st == ST_IDLE && !stop_req && status == S_IDLE));

  p_lost_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && status == S_LOST) |-> (!scl_drv && !sda_drv));

  p_cfg_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=> $stable({en, rate}));
endmodule

// File: tb/i2c_event_master_tb_top.sv
module i2c_event_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_o, status_o, data_o;
  logic irq_o, scl_drive_low, sda_drive_low;
  logic slave_sda = 1'b0, ext_sda = 1'b0;
  wire scl_in = !scl_drive_low;
  wire sda_in = !(sda_drive_low | slave_sda | ext_sda);

  i2c_event_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_o(ctrl_o), .status_o(status_o), .data_o(data_o), .irq_o(irq_o),
    .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low));

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, period = 0, viol = 0;
  bit byte_phase = 1'b0;
  logic [2:0] cur_rate = 3'd0;

  // bench slave
  int s_cnt = -2, s_ti = 0, s_nl = 0;
  logic s_addr = 1'b0, s_tx = 1'b0, s_mack = 1'b0;
  logic [7:0] s_sh = 8'h00;
  logic [7:0] s_txb [4];
  logic [7:0] s_log [8];
  bit s_ack_addr = 1'b1, s_ack_data = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge scl_in) begin period = cyc - last_rise; last_rise = cyc; end
  always @(sda_in) if (byte_phase && scl_in === 1'b1) viol++;

  always @(negedge sda_in) if (scl_in === 1'b1) begin s_cnt = -1; s_addr = 1'b1; s_tx = 1'b0; slave_sda = 1'b0; end
  always @(posedge sda_in) if (scl_in === 1'b1) begin s_cnt = -2; slave_sda = 1'b0; end
  always @(posedge scl_in) begin
    if (s_cnt >= 0 && s_cnt < 8) s_sh = {s_sh[6:0], sda_in};
    else if (s_cnt == 8) s_mack = !sda_in;
  end
  always @(negedge scl_in) if (s_cnt >= -1) begin
    s_cnt = s_cnt + 1;
    if (s_cnt == 8) begin
      if (s_tx) slave_sda = 1'b0;
      else begin
        s_log[s_nl % 8] = s_sh; s_nl++;
        slave_sda = s_addr ? s_ack_addr : s_ack_data;
      end
    end else if (s_cnt == 9) begin
      s_cnt = 0;
      if (s_addr) begin
        s_tx = s_sh[0] && s_ack_addr; s_addr = 1'b0;
        slave_sda = s_tx ? !s_txb[s_ti][7] : 1'b0;
      end else if (s_tx) begin
        if (s_mack) begin s_ti++; slave_sda = !s_txb[s_ti][7]; end
        else begin slave_sda = 1'b0; s_tx = 1'b0; end
      end else slave_sda = 1'b0;
    end else if (s_tx && s_cnt >= 1) slave_sda = !s_txb[s_ti][7 - s_cnt];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input bit st, input bit sp, input bit ak);
    return {cur_rate, 1'b1, st, sp, 1'b0, ak};
  endfunction

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq_o && n < 30000) begin @(negedge clk); n++; end
    if (!irq_o) check(1'b0, {tag, " irq timeout"}, 0, 1);
  endtask

  task automatic begin_start(input logic [7:0] addr);
    wr(2'd1, addr); wr(2'd0, ctl(1, 0, 0)); wait_irq("R2");
    check(status_o == 8'h08, "R2 start status", status_o, 8'h08);
  endtask

  task automatic xfer(input logic [7:0] d, input bit wd, input bit ak, input logic [7:0] exp_st, input string tag);
    if (wd) wr(2'd1, d);
    byte_phase = 1'b1; wr(2'd0, ctl(0, 0, ak)); wait_irq(tag); byte_phase = 1'b0;
    check(status_o == exp_st, tag, status_o, exp_st);
  endtask

  task automatic finish_stop();
    int n = 0;
    wr(2'd0, ctl(0, 1, 0));
    while (ctrl_o[2] && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(status_o == 8'hF8 && !irq_o && !ctrl_o[2], "R8 stop status/flag/request", status_o, 8'hF8);
    check(!scl_drive_low && !sda_drive_low && scl_in && sda_in, "R8 lines released",
          {scl_drive_low, sda_drive_low}, 0);
  endtask

  task automatic t_reset();
    check(ctrl_o == 8'h00 && status_o == 8'hF8 && !irq_o, "R1 reset registers", {ctrl_o, status_o}, 16'h00F8);
    check(!scl_drive_low && !sda_drive_low, "R1 reset lines", {scl_drive_low, sda_drive_low}, 0);
  endtask

  task automatic t_write();
    cur_rate = 3'd0; s_ack_addr = 1'b1; s_ack_data = 1'b1; s_nl = 0;
    begin_start(8'hA4);
    repeat (300) @(negedge clk);
    check(scl_in == 1'b0 && irq_o && status_o == 8'h08, "R3 stall holds SCL low", scl_in, 0);
    xfer(8'hA4, 0, 0, 8'h18, "R4 address write ack");
    check(s_log[0] == 8'hA4, "R4 address bits on bus", s_log[0], 8'hA4);
    check(period == 128, "R9 rate code 0 period", period, 128);
    xfer(8'h3C, 1, 0, 8'h28, "R5 data ack");
    check(s_log[1] == 8'h3C, "R5 data on bus", s_log[1], 8'h3C);
    s_ack_data = 1'b0;
    xfer(8'h55, 1, 0, 8'h30, "R5 data nack");
    s_ack_data = 1'b1;
    finish_stop();
  endtask

  task automatic t_rates();
    int exp_div [8] = '{128, 112, 96, 80, 480, 60, 30, 192};
    wr(2'd2, 8'd254);
    for (int c = 1; c < 8; c++) begin
      cur_rate = 3'(c);
      begin_start(8'hA4);
      xfer(8'hA4, 0, 0, 8'h18, "R9 address");
      check(period == exp_div[c], "R9 rate period", period, exp_div[c]);
      finish_stop();
      check(ctrl_o[7:4] == {cur_rate, 1'b1}, "R12 enable and rate untouched", ctrl_o[7:4], {cur_rate, 1'b1});
    end
    cur_rate = 3'd0;
  endtask

  task automatic t_read();
    s_txb[0] = 8'hC3; s_txb[1] = 8'h5A; s_txb[2] = 8'hFF; s_txb[3] = 8'hFF; s_ti = 0;
    begin_start(8'hA5);
    xfer(8'hA5, 0, 0, 8'h40, "R4 address read ack");
    xfer(8'h00, 0, 1, 8'h50, "R6 receive with ack");
    check(data_o == 8'hC3, "R6 received byte 1", data_o, 8'hC3);
    check(s_mack == 1'b1, "R6 master sent ACK", s_mack, 1);
    xfer(8'h00, 0, 0, 8'h58, "R6 receive with nack");
    check(data_o == 8'h5A, "R6 received byte 2", data_o, 8'h5A);
    check(s_mack == 1'b0, "R6 master sent NACK", s_mack, 0);
    finish_stop();
  endtask

  task automatic t_rstart();
    s_txb[0] = 8'hC3; s_ti = 0;
    begin_start(8'hA4);
    xfer(8'hA4, 0, 0, 8'h18, "R7 first address");
    wr(2'd0, ctl(1, 0, 0)); wait_irq("R7");
    check(status_o == 8'h10, "R7 repeated start status", status_o, 8'h10);
    xfer(8'hA5, 1, 0, 8'h40, "R7 read after repeated start");
    finish_stop();
  endtask

  task automatic t_addr_nack();
    s_ack_addr = 1'b0;
    begin_start(8'hA4);
    xfer(8'hA4, 0, 0, 8'h20, "R4 address write nack");
    finish_stop();
    begin_start(8'hA5);
    xfer(8'hA5, 0, 0, 8'h48, "R4 address read nack");
    finish_stop();
    s_ack_addr = 1'b1;
  endtask

  task automatic t_busy();
    ext_sda = 1'b1;
    repeat (20) @(negedge clk);
    wr(2'd1, 8'hA4); wr(2'd0, ctl(1, 0, 0));
    repeat (2000) @(negedge clk);
    check(!irq_o && !scl_drive_low && !sda_drive_low, "R2 no START while bus owned", irq_o, 0);
    ext_sda = 1'b0;
    wait_irq("R2");
    check(status_o == 8'h08, "R2 START after foreign STOP", status_o, 8'h08);
    xfer(8'hA4, 0, 0, 8'h18, "R2 address after wait");
    finish_stop();
  endtask

  task automatic t_flag_write();
    wr(2'd0, 8'h12);
    repeat (10) @(negedge clk);
    check(!irq_o && !ctrl_o[1], "R3 software cannot set flag", irq_o, 0);
  endtask

  task automatic t_arb();
    begin_start(8'hA4);
    ext_sda = 1'b1;
    wr(2'd0, ctl(0, 0, 0)); wait_irq("R11");
    check(status_o == 8'h38, "R11 arbitration lost status", status_o, 8'h38);
    check(!scl_drive_low && !sda_drive_low, "R11 lines released", {scl_drive_low, sda_drive_low}, 0);
    ext_sda = 1'b0;
    repeat (10) @(negedge clk);
    wr(2'd0, ctl(0, 0, 0));
    repeat (10) @(negedge clk);
    check(!irq_o && !scl_drive_low, "R11 idle after clear", irq_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_rstart();
    t_addr_nack();
    t_busy();
    t_flag_write();
    t_arb();
    t_rates();
    check(viol == 0, "R10 SDA moved while SCL high in a byte", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule